// File: doc/BRIEF.md
# SDLC Transmit Frame Sequencer

This block runs the byte-level side of an SDLC transmission. Software selects transmit mode with a request-to-send level. Once clear-to-send is also active, the sequencer puts the opening flag into its outgoing byte register. Two pre-frame sync bytes can optionally follow the flag. The sequencer then loads a RAM pointer and a byte count from the buffer configuration and streams the buffer out one byte per byte boundary. After the last data byte it hands two byte slots to the CRC generator of the bit-level back end, unless the no-FCS option is set. It finishes with a closing flag.

The bit-level back end handles serial shifting, zero insertion and the CRC itself. It pulses `boundary_i` each time it takes `byte_o` for shifting. The sequencer replies at that same clock edge with the next byte and its attributes:
- whether zero insertion applies to it;
- whether the slot carries CRC instead of `byte_o`.

Boundaries are accepted only in waiting states. The back end leaves at least three clock cycles between boundary pulses.

Top module: `sdlc_tx_seq`

## Requirements
- R1: While `rts_i` and `cts_i` are not both high in idle, the sequencer stays idle. In that state `busy_o` is low, `boundary_i` pulses are ignored and `byte_o`, `zi_en_o`, `fcs_en_o` and `fcs_send_o` keep their values.
- R2: After `rts_i` and `cts_i` are both seen high in idle, `byte_o` holds 7Eh within two clocks. In that state `zi_en_o` is low and `busy_o` is high.
- R3: With `pfs_en_i` high, the first two boundaries load a sync byte with `zi_en_o` low. The sync byte is 00h when `pfs_pat_i` is 0 and 55h when it is 1.
- R4: Zero insertion switches back on (`zi_en_o` high) by itself at the boundary that loads the first data byte.
- R5: Before the first data boundary, `ram_addr_o` equals `buf_start_i`, `fcs_en_o` is high and `zi_en_o` is low. Without pre-frame sync, no sync byte is emitted.
- R6: Each data boundary loads `byte_o` with the RAM byte at `ram_addr_o`, pulses `ram_rd_o` and increments `ram_addr_o` modulo the address range. Exactly `buf_len_i` data bytes are sent; a length of 0 sends one byte.
- R7: With `nfcs_i` low, the two boundaries after the last data byte set `fcs_send_o` high. From the first of them, `fcs_en_o` is low.
- R8: With `nfcs_i` high, no CRC slot is produced: `fcs_send_o` stays low and the boundary after the last data byte loads the closing flag.
- R9: The closing flag 7Eh is loaded with `zi_en_o` low and `fcs_send_o` low. The next boundary gives a one-cycle `done_o` pulse and returns the sequencer to idle with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rts_i | input | 1 | Transmit mode request from software |
| cts_i | input | 1 | Clear-to-send, active high |
| pfs_en_i | input | 1 | Send two pre-frame sync bytes |
| pfs_pat_i | input | 1 | Sync pattern: 0 gives 00h, 1 gives 55h |
| nfcs_i | input | 1 | Suppress the CRC bytes |
| buf_start_i | input | AW | First RAM address of the frame buffer |
| buf_len_i | input | LW | Number of data bytes |
| ram_addr_o | output | AW | RAM read address |
| ram_rd_o | output | 1 | RAM read strobe, one per data byte |
| ram_data_i | input | 8 | RAM read data, valid in the same cycle as the address |
| boundary_i | input | 1 | Back end has taken `byte_o` |
| byte_o | output | 8 | Next byte to shift |
| zi_en_o | output | 1 | Zero insertion applies to the next byte |
| fcs_en_o | output | 1 | CRC accumulation enable |
| fcs_send_o | output | 1 | Next slot carries CRC instead of `byte_o` |
| busy_o | output | 1 | Sequencer is out of idle |
| done_o | output | 1 | One-cycle pulse when the closing flag has been taken |

## Verification
The start decision is registered, and the opening flag is loaded one clock later. The bench therefore waits four clocks after raising both start inputs before it checks the flag and `busy_o`. Every later result, including the `done_o` pulse, is registered on the same edge that samples `boundary_i`. The bench checks each of these at the falling edge that directly follows its one-cycle boundary pulse. The pointer load in the flag state takes one extra clock after the last pre-start byte. Boundary pulses are therefore spaced three clocks apart, and the pointer and CRC-enable checks for R5 fall inside that gap.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SYNC1, ST_SYNC2, ST_FLAG,
    ST_DATA, ST_CRC1, ST_CRC2, ST_CLOSE, ST_DONE
  } tx_state_e;

  typedef enum logic [1:0] {SRC_FLAG, SRC_SYNC, SRC_RAM, SRC_HOLD} src_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] SYNC_ALT  = 8'h55;
  localparam logic [7:0] SYNC_ZERO = 8'h00;
endpackage

// File: rtl/sdlc_tx_ctrl.sv
module sdlc_tx_ctrl
  import sdlc_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rts_i,
  input  logic cts_i,
  input  logic pfs_en_i,
  input  logic nfcs_i,
  input  logic boundary_i,
  input  logic last_i,
  output logic busy_o,
  output logic out_ld_o,
  output src_e out_sel_o,
  output logic zi_v_o,
  output logic fcs_v_o,
  output logic dma_load_o,
  output logic dma_step_o,
  output logic fcs_en_o,
  output logic done_o
);
  tx_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    out_ld_o   = 1'b0;
    out_sel_o  = SRC_HOLD;
    zi_v_o     = 1'b0;
    fcs_v_o    = 1'b0;
    dma_load_o = 1'b0;
    dma_step_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (rts_i && cts_i) state_d = ST_START;
      ST_START: begin
        out_ld_o  = 1'b1;
        out_sel_o = SRC_FLAG;
        state_d   = pfs_en_i ? ST_SYNC1 : ST_FLAG;
      end
      ST_SYNC1: if (boundary_i) begin
        out_ld_o  = 1'b1;
        out_sel_o = SRC_SYNC;
        state_d   = ST_SYNC2;
      end
      ST_SYNC2: if (boundary_i) begin
        out_ld_o  = 1'b1;
        out_sel_o = SRC_SYNC;
        state_d   = ST_FLAG;
      end
      ST_FLAG: begin
        dma_load_o = 1'b1;
        state_d    = ST_DATA;
      end
      ST_DATA: if (boundary_i) begin
        out_ld_o   = 1'b1;
        out_sel_o  = SRC_RAM;
        zi_v_o     = 1'b1;  // automatic re-enable after flag/sync
        dma_step_o = 1'b1;
        if (last_i) state_d = nfcs_i ? ST_CLOSE : ST_CRC1;
      end
      ST_CRC1: if (boundary_i) begin
        out_ld_o = 1'b1;
        zi_v_o   = 1'b1;
        fcs_v_o  = 1'b1;
        state_d  = ST_CRC2;
      end
      ST_CRC2: if (boundary_i) begin
        out_ld_o = 1'b1;
        zi_v_o   = 1'b1;
        fcs_v_o  = 1'b1;
        state_d  = ST_CLOSE;
      end
      ST_CLOSE: if (boundary_i) begin
        out_ld_o  = 1'b1;
        out_sel_o = SRC_FLAG;
        state_d   = ST_DONE;
      end
      ST_DONE:  if (boundary_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fcs_en_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_DONE) && boundary_i;
      if (state_q == ST_FLAG) fcs_en_o <= 1'b1;
      else if (boundary_i && (state_q == ST_CRC1 || state_q == ST_CLOSE)) fcs_en_o <= 1'b0;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !(rts_i && cts_i)) |=> (state_q == ST_IDLE));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));
endmodule

// File: rtl/sdlc_tx_dma.sv
module sdlc_tx_dma #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  localparam logic [LW-1:0] CNT_ONE = LW'(1);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      ptr_o <= start_i;
      cnt_q <= (len_i == '0) ? '0 : len_i - CNT_ONE;  // zero length sends one byte
    end else if (step_i) begin
      ptr_o <= ptr_o + AW'(1);
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign last_o = (cnt_q == '0);

  assert_ptr_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_o == $past(start_i)));
  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (ptr_o == $past(ptr_o) + AW'(1)));
endmodule

// File: rtl/sdlc_tx_outreg.sv
module sdlc_tx_outreg
  import sdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  src_e       sel_i,
  input  logic       zi_v_i,
  input  logic       fcs_v_i,
  input  logic       pfs_pat_i,
  input  logic [7:0] ram_data_i,
  output logic [7:0] byte_o,
  output logic       zi_en_o,
  output logic       fcs_send_o
);
  logic [7:0] byte_d;

  always_comb begin
    unique case (sel_i)
      SRC_FLAG: byte_d = FLAG_BYTE;
      SRC_SYNC: byte_d = pfs_pat_i ? SYNC_ALT : SYNC_ZERO;
      SRC_RAM:  byte_d = ram_data_i;
      default:  byte_d = byte_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= '0;
      zi_en_o    <= 1'b0;
      fcs_send_o <= 1'b0;
    end else if (ld_i) begin
      byte_o     <= byte_d;
      zi_en_o    <= zi_v_i;
      fcs_send_o <= fcs_v_i;
    end
  end

  assert_sync_no_zi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && sel_i == SRC_SYNC) |=> (!zi_en_o && (byte_o == SYNC_ALT || byte_o == SYNC_ZERO)));
  assert_flag_no_zi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && sel_i == SRC_FLAG) |=> (!zi_en_o && !fcs_send_o));
endmodule

// File: rtl/sdlc_tx_seq.sv
module sdlc_tx_seq
  import sdlc_tx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rts_i,
  input  logic          cts_i,
  input  logic          pfs_en_i,
  input  logic          pfs_pat_i,
  input  logic          nfcs_i,
  input  logic [AW-1:0] buf_start_i,
  input  logic [LW-1:0] buf_len_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_rd_o,
  input  logic [7:0]    ram_data_i,
  input  logic          boundary_i,
  output logic [7:0]    byte_o,
  output logic          zi_en_o,
  output logic          fcs_en_o,
  output logic          fcs_send_o,
  output logic          busy_o,
  output logic          done_o
);
  logic out_ld, zi_v, fcs_v, dma_load, dma_step, last;
  src_e out_sel;

  sdlc_tx_ctrl u_ctrl (
    .clk_i, .rst_ni, .rts_i, .cts_i, .pfs_en_i, .nfcs_i, .boundary_i,
    .last_i(last), .busy_o, .out_ld_o(out_ld), .out_sel_o(out_sel),
    .zi_v_o(zi_v), .fcs_v_o(fcs_v), .dma_load_o(dma_load),
    .dma_step_o(dma_step), .fcs_en_o, .done_o
  );

  sdlc_tx_dma #(.AW(AW), .LW(LW)) u_dma (
    .clk_i, .rst_ni, .load_i(dma_load), .step_i(dma_step),
    .start_i(buf_start_i), .len_i(buf_len_i), .ptr_o(ram_addr_o), .last_o(last)
  );

  sdlc_tx_outreg u_out (
    .clk_i, .rst_ni, .ld_i(out_ld), .sel_i(out_sel), .zi_v_i(zi_v),
    .fcs_v_i(fcs_v), .pfs_pat_i, .ram_data_i, .byte_o, .zi_en_o, .fcs_send_o
  );

  assign ram_rd_o = dma_step;

  assert_crc_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fcs_send_o) |-> !fcs_en_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_rd_o);
  assert_end_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/sdlc_tx_seq_bench.sv
`timescale 1ns/1ps
module sdlc_tx_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rts = 1'b0, cts = 1'b0, pfs_en = 1'b0, pfs_pat = 1'b0, nfcs = 1'b0;
  logic [7:0] buf_start = '0, buf_len = '0;
  logic [7:0] ram_addr, ram_data, byte_v;
  logic       ram_rd, bnd = 1'b0, zi, fcs_en, fcs_send, busy, done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_f(input logic [7:0] a);
    return (a * 8'd7) ^ 8'h3C;
  endfunction
  assign ram_data = ram_f(ram_addr);

  sdlc_tx_seq u_sdlc_tx_seq (
    .clk_i(clk), .rst_ni(rst_n), .rts_i(rts), .cts_i(cts), .pfs_en_i(pfs_en),
    .pfs_pat_i(pfs_pat), .nfcs_i(nfcs), .buf_start_i(buf_start), .buf_len_i(buf_len),
    .ram_addr_o(ram_addr), .ram_rd_o(ram_rd), .ram_data_i(ram_data),
    .boundary_i(bnd), .byte_o(byte_v), .zi_en_o(zi), .fcs_en_o(fcs_en),
    .fcs_send_o(fcs_send), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one-cycle boundary; returns with outputs of that edge visible
  task automatic pulse;
    repeat (3) @(negedge clk);
    bnd = 1'b1;
    @(negedge clk);
    bnd = 1'b0;
  endtask

  task automatic test_idle;
    rts = 1'b0; cts = 1'b1;
    repeat (10) @(negedge clk);
    pulse();
    chk(busy == 1'b0, "R1 busy rts low", busy, 0);
    chk(byte_v == 8'h00 && zi == 1'b0, "R1 byte rts low", byte_v, 0);
    rts = 1'b1; cts = 1'b0;
    repeat (10) @(negedge clk);
    pulse();
    chk(busy == 1'b0, "R1 busy cts low", busy, 0);
    chk(fcs_en == 1'b0 && fcs_send == 1'b0, "R1 fcs idle", {fcs_en, fcs_send}, 0);
    rts = 1'b0;
  endtask

  task automatic test_frame(input bit pfs, input bit pat, input bit nf,
                            input logic [7:0] st, input logic [7:0] len);
    int n;
    pfs_en = pfs; pfs_pat = pat; nfcs = nf; buf_start = st; buf_len = len;
    n = (len == 0) ? 1 : int'(len);
    @(negedge clk);
    rts = 1'b1; cts = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_v == 8'h7E, "R2 opening flag", byte_v, 8'h7E);
    chk(busy == 1'b1 && zi == 1'b0, "R2 busy/zi", {busy, zi}, 2'b10);
    if (pfs) begin
      for (int k = 0; k < 2; k++) begin
        pulse();
        chk(byte_v == (pat ? 8'h55 : 8'h00), "R3 sync byte", byte_v, pat ? 8'h55 : 8'h00);
        chk(zi == 1'b0, "R3 sync zi off", zi, 0);
      end
    end
    repeat (2) @(negedge clk);
    chk(ram_addr == st, "R5 pointer load", ram_addr, st);
    chk(fcs_en == 1'b1 && zi == 1'b0, "R5 fcs on zi off", {fcs_en, zi}, 2'b10);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = st + 8'(i);
      pulse();
      chk(byte_v == ram_f(a), "R6 data byte", byte_v, ram_f(a));
      chk(ram_addr == 8'(a + 8'd1), "R6 pointer step", ram_addr, 8'(a + 8'd1));
      if (i == 0) chk(zi == 1'b1, "R4 zi auto on", zi, 1);
    end
    if (!nf) begin
      for (int k = 0; k < 2; k++) begin
        pulse();
        chk(fcs_send == 1'b1 && fcs_en == 1'b0, "R7 crc slot", {fcs_send, fcs_en}, 2'b10);
      end
    end
    rts = 1'b0; cts = 1'b0;
    pulse();
    chk(byte_v == 8'h7E, "R9 closing flag", byte_v, 8'h7E);
    chk(zi == 1'b0 && fcs_send == 1'b0, nf ? "R8 no crc slot" : "R9 flag attrs",
        {zi, fcs_send}, 0);
    chk(fcs_en == 1'b0, "R7 fcs off at end", fcs_en, 0);
    pulse();
    chk(done == 1'b1, "R9 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 back to idle", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && byte_v == 0 && zi == 0 && fcs_en == 0 && fcs_send == 0 && done == 0,
        "R1 reset state", {busy, byte_v}, 0);
    test_idle();
    test_frame(1'b0, 1'b0, 1'b0, 8'h10, 8'd2);
    test_frame(1'b1, 1'b1, 1'b0, 8'hFE, 8'd3);
    test_frame(1'b1, 1'b0, 1'b1, 8'h40, 8'd1);
    test_frame(1'b0, 1'b0, 1'b1, 8'h80, 8'd0);
    test_frame(1'b0, 1'b1, 1'b0, 8'h20, 8'd5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule